// File: doc/BRIEF.md
# Two-Wire Serial Slave Front End

This block is the slave side of a two-wire serial bus. The bus master drives the clock line and both sides share a wired-AND data line. The block brings both lines into the system clock domain and finds the start and stop conditions in them. It decodes a one-byte slave address, which is a fixed device-type nibble followed by a nibble that must equal four strap pins. After that it takes a command byte and an optional data byte, and it pulls the data line low to acknowledge each byte it accepts.

Each accepted byte reaches the register logic behind the block as a one-cycle strobe with the byte beside it. A command whose top bit is set asks for a read. For a read, the block shifts a byte supplied by the register logic out onto the bus. It repeats the byte for as long as the master acknowledges, and it stops driving the bus after the master's first missing acknowledge.

Top module: `twowire_slave`

## Requirements
- R1: After reset the data-line pull-down (`sda_oe`) is off and neither strobe is asserted.
- R2: Until a start condition is seen (data falling while clock is high), bytes on the bus get no acknowledge and no strobe.
- R3: A stop condition (data rising while clock is high) returns the block to idle. A byte cut short by a stop produces no strobe.
- R4: The block changes `sda_oe` only while the clock line is low. It holds the acknowledge low for the whole high phase of the ninth clock.
- R5: The address byte is acknowledged only if bits 7..4 equal binary 0101 and bits 3..0 equal `strap_addr`. On a mismatch the block does not acknowledge and ignores everything until the next start.
- R6: A command byte after a matching address is acknowledged. `cmd_stb` pulses for one cycle with the byte on `cmd_out`.
- R7: For a command with bit 7 clear, one following data byte is acknowledged and `data_stb` pulses for one cycle with it on `data_out`. Any further byte in the same transaction is not acknowledged.
- R8: For a command with bit 7 set, the block shifts `rd_data` out MSB first after the command acknowledge. It sends the byte again after each master acknowledge, and after a master non-acknowledge it releases the line until the next start or stop.
- R9: A start condition in the middle of a transaction, a repeated start, restarts the address phase and discards any partial byte.
- R10: Bits are taken most-significant first, sampled on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as received |
| sda_in | input | 1 | Bus data line as received (wired-AND level) |
| strap_addr | input | 4 | Pin-strapped low address nibble |
| rd_data | input | 8 | Byte returned on a read command |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| cmd_out | output | 8 | Last accepted command byte |
| cmd_stb | output | 1 | One-cycle pulse when a command byte is accepted |
| data_out | output | 8 | Last accepted data byte |
| data_stb | output | 1 | One-cycle pulse when a data byte is accepted |

## Verification
The bench sends random addresses in which the type nibble or the strap nibble is sometimes wrong. A decoder that compares only one of the two nibbles would acknowledge a foreign address and then accept a command meant for another device. It cuts a data byte short with a stop, and it interrupts a command byte with a repeated start. A design that kept the partial shift state would strobe a corrupted byte, or it would acknowledge the next address one bit late. Read transactions of one to three bytes check the bit order and the release after the master's non-acknowledge. A monitor flags any change of the pull-down while the clock is high, because that change would look like a false start or stop on the bus.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam logic [3:0] DEV_TYPE_DEFAULT = 4'b0101;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_DATA,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_DONE
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic d_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  // R3/R9: a bus condition can never coincide with a clock edge
  a_r9_cond_clock_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |-> !(scl_rise || scl_fall));
  a_r3_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt && stop_evt));
endmodule

// File: rtl/tw_engine.sv
module tw_engine #(
  parameter int         BYTE_W   = 8,
  parameter logic [3:0] DEV_TYPE = tw_pkg::DEV_TYPE_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [3:0]        strap_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] cmd_out,
  output logic              cmd_stb,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_stb
);
  import tw_pkg::*;

  localparam int CW  = $clog2(BYTE_W + 1);
  localparam int MSB = BYTE_W - 1;
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  function automatic logic addr_match(input logic [BYTE_W-1:0] a,
                                      input logic [3:0] strap);
    return (a[MSB -: 4] == DEV_TYPE) && (a[3:0] == strap);
  endfunction

  function automatic logic is_read(input logic [BYTE_W-1:0] c);
    return c[MSB];
  endfunction

  tw_state_e         st, after;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;
  logic              mack;
  logic              addr_hit;
  logic              byte_done;

  assign addr_hit  = addr_match(rx_sh, strap_addr);
  assign byte_done = scl_fall && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      after    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
      cmd_out  <= '0;
      data_out <= '0;
      cmd_stb  <= 1'b0;
      data_stb <= 1'b0;
    end else begin
      cmd_stb  <= 1'b0;
      data_stb <= 1'b0;
      if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_evt) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_CMD, ST_DATA: begin
            if (scl_rise && cnt != FULL) begin
              rx_sh <= {rx_sh[MSB-1:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  st     <= ST_ACK;
                  after  <= ST_CMD;
                  sda_oe <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_CMD) begin
                cmd_out <= rx_sh;
                cmd_stb <= 1'b1;
                sda_oe  <= 1'b1;
                st      <= ST_ACK;
                after   <= is_read(rx_sh) ? ST_RD : ST_DATA;
              end else begin
                data_out <= rx_sh;
                data_stb <= 1'b1;
                sda_oe   <= 1'b1;
                st       <= ST_ACK;
                after    <= ST_DONE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              st  <= after;
              cnt <= '0;
              if (after == ST_RD) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[MSB];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_RACK;
              end else begin
                tx_sh  <= {tx_sh[MSB-1:0], 1'b0};
                sda_oe <= ~tx_sh[MSB-1];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                st     <= ST_RD;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[MSB];
              end else begin
                st <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: pull-down moves only while the synchronised clock is low
  a_r4_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R2: nothing is driven while idle
  a_r2_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R5: a mismatching address is never acknowledged
  a_r5_no_ack_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR && byte_done && !addr_hit) |=> (st == ST_IDLE && !sda_oe));
  // R6: command strobe coincides with the acknowledge
  a_r6_cmd_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> sda_oe);
  a_r6_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);
  // R7: data strobe coincides with the acknowledge and never with the command strobe
  a_r7_data_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    data_stb |-> sda_oe);
  a_r7_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_stb && data_stb));
  // R8: after the master's non-acknowledge the line stays released
  a_r8_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DONE) |-> !sda_oe);
  // R3: a stop idles the block without a strobe
  a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe && !data_stb && !cmd_stb));
  // R9: a start always restarts the address phase from bit zero
  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR && cnt == '0));
endmodule

// File: rtl/twowire_slave.sv
module twowire_slave #(
  parameter int         BYTE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = tw_pkg::DEV_TYPE_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [3:0]        strap_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] cmd_out,
  output logic              cmd_stb,
  output logic [BYTE_W-1:0] data_out,
  output logic              data_stb
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  tw_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (
    .clk(clk), .rst_n(rst_n), .d_async(scl_in), .d_sync(scl_s));
  tw_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (
    .clk(clk), .rst_n(rst_n), .d_async(sda_in), .d_sync(sda_s));

  tw_bus_events i_events (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt));

  tw_engine #(.BYTE_W(BYTE_W), .DEV_TYPE(DEV_TYPE)) i_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap_addr(strap_addr), .rd_data(rd_data),
    .sda_oe(sda_oe), .cmd_out(cmd_out), .cmd_stb(cmd_stb),
    .data_out(data_out), .data_stb(data_stb));
endmodule

// File: tb/test_twowire_slave.sv
module test_twowire_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [3:0] strap = 4'h0;
  logic [7:0] rd_data = 8'h00;
  logic       sda_oe, cmd_stb, data_stb;
  logic [7:0] cmd_out, data_out;
  wire        sda_line = m_sda & ~sda_oe;

  int checks = 0, fails = 0;
  int n_cmd = 0, n_data = 0, r4_bad = 0;
  logic [7:0] last_cmd = 8'h00, last_data = 8'h00, cmd_at_data = 8'h00;
  logic prev_oe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twowire_slave i_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .strap_addr(strap), .rd_data(rd_data), .sda_oe(sda_oe),
    .cmd_out(cmd_out), .cmd_stb(cmd_stb), .data_out(data_out), .data_stb(data_stb));

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_stb) begin n_cmd++; last_cmd = cmd_out; end
      if (data_stb) begin n_data++; last_data = data_out; cmd_at_data = cmd_out; end
      if (sda_oe != prev_oe && m_scl) r4_bad++;
    end
    prev_oe = sda_oe;
  end

  function automatic bit exp_hit(input logic [7:0] a, input logic [3:0] s);
    return (a >> 4) == 8'h05 && (a & 8'h0F) == {4'h0, s};
  endfunction

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    w(Q); m_sda = b; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
    ack = ~sda_line; w(Q); m_scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
      b[i] = sda_line; w(Q); m_scl = 1'b0;
    end
    w(Q); m_sda = ~mack; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0;
  endtask

  task automatic bus_start;
    w(Q); m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b0;
  endtask

  task automatic bus_stop;
    w(Q); m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(2*Q);
  endtask

  // mode: write 0 = no data, 1 = data, 2 = data + extra; read = byte count
  task automatic run_txn(input logic [7:0] addr, input logic [7:0] cmd,
                         input int mode, input logic [7:0] dbyte);
    bit ack;
    int c0, d0;
    logic [7:0] b;
    c0 = n_cmd; d0 = n_data;
    bus_start;
    send_byte(addr, ack);
    check(ack == exp_hit(addr, strap), "R5", "address ack", ack, exp_hit(addr, strap));
    if (!exp_hit(addr, strap)) begin
      send_byte(cmd, ack);
      check(!ack && n_cmd == c0, "R5", "ignored after miss", n_cmd - c0, 0);
      bus_stop;
      return;
    end
    send_byte(cmd, ack);
    check(ack, "R6", "command ack", ack, 1);
    check(n_cmd == c0 + 1 && last_cmd == cmd, "R10", "command byte", last_cmd, cmd);
    if (cmd[7]) begin
      for (int k = 0; k < mode; k++) begin
        recv_byte(b, k != mode - 1);
        check(b == rd_data, "R8", "read byte", b, rd_data);
      end
      send_bit(1'b1);
      check(sda_oe == 1'b0, "R8", "released after nack", sda_oe, 0);
      check(n_data == d0, "R8", "no data strobe on read", n_data - d0, 0);
    end else if (mode >= 1) begin
      send_byte(dbyte, ack);
      check(ack, "R7", "data ack", ack, 1);
      check(n_data == d0 + 1 && last_data == dbyte && cmd_at_data == cmd,
            "R7", "data byte", last_data, dbyte);
      if (mode == 2) begin
        send_byte(~dbyte, ack);
        check(!ack && n_data == d0 + 1, "R7", "extra byte refused", ack, 0);
      end
    end
    bus_stop;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit ack;
    int c0, d0;
    logic [7:0] a, c;
    void'($urandom(32'd2024));
    w(5);
    // R1 reset state
    check(sda_oe == 1'b0 && cmd_stb == 1'b0 && data_stb == 1'b0, "R1", "reset outputs",
          {sda_oe, cmd_stb, data_stb}, 0);
    rst_n = 1'b1;
    strap = 4'hA;
    w(10);

    // R2 bytes before any start are ignored
    m_scl = 1'b0; w(Q);
    send_byte(8'h5A, ack);
    check(!ack, "R2", "no ack before start", ack, 0);
    send_byte(8'h12, ack);
    check(!ack && n_cmd == 0, "R2", "no strobe before start", n_cmd, 0);
    bus_stop;

    // R5 directed: wrong type nibble, wrong strap nibble, good address
    run_txn(8'h6A, 8'h01, 1, 8'h33);
    run_txn(8'h5B, 8'h01, 1, 8'h33);
    run_txn(8'h5A, 8'h21, 1, 8'hC4);

    // R3 stop in the middle of a data byte
    c0 = n_cmd; d0 = n_data;
    bus_start;
    send_byte(8'h5A, ack);
    send_byte(8'h07, ack);
    for (int i = 0; i < 4; i++) send_bit(i[0]);
    bus_stop;
    check(n_data == d0 && n_cmd == c0 + 1, "R3", "partial byte dropped", n_data - d0, 0);
    check(sda_oe == 1'b0, "R3", "idle after stop", sda_oe, 0);

    // R9 repeated start inside a command byte
    c0 = n_cmd; d0 = n_data;
    bus_start;
    send_byte(8'h5A, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    bus_start;
    send_byte(8'h5A, ack);
    check(ack, "R9", "address after restart", ack, 1);
    send_byte(8'h4C, ack);
    send_byte(8'h99, ack);
    bus_stop;
    check(n_cmd == c0 + 1 && last_cmd == 8'h4C && last_data == 8'h99 && n_data == d0 + 1,
          "R9", "restart discards partial", last_cmd, 8'h4C);

    // R8 directed read, one and three bytes
    rd_data = 8'hB6;
    run_txn(8'h5A, 8'h85, 1, 8'h00);
    rd_data = 8'h01;
    run_txn(8'h5A, 8'hF0, 3, 8'h00);

    // random mix
    for (int t = 0; t < 24; t++) begin
      int kind;
      strap = 4'($urandom);
      kind = int'($urandom % 5);
      a = {4'h5, strap};
      if (kind == 0) a[7:4] = 4'h5 ^ (4'h1 + 4'($urandom % 15));
      else if (kind == 1) a[3:0] = strap ^ (4'h1 + 4'($urandom % 15));
      c = 8'($urandom);
      rd_data = 8'($urandom);
      if (c[7]) run_txn(a, c, 1 + int'($urandom % 3), 8'h00);
      else      run_txn(a, c, int'($urandom % 3), 8'($urandom));
    end

    // R4 no pull-down change while clock high
    check(r4_bad == 0, "R4", "oe change with scl high", r4_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule